// File: doc/BRIEF.md
# Stack-Machine Program Counter Sequencer

This block owns the program counter of a byte-addressed stack machine. Every opcode occupies one byte. A push opcode carries between 1 and 32 immediate bytes, and the sequencer must step over them. On each executed instruction the block looks at the opcode byte and the top two stack values. For a taken jump it consults an external lookup that reports whether a byte address holds a jump-destination marker. From these it produces the next PC, the number of stack entries the instruction consumes, and a fault when a jump would land anywhere but on a marker.

The lookup works combinationally. The block presents the low PC bits of the destination value on `probe_addr`, and the surrounding logic answers on `dest_marked` in the same cycle. That map must already exclude marker-valued bytes that sit inside push immediates. A fault freezes the PC and raises a halt flag that only reset clears. Stack storage, code memory and the arithmetic opcodes belong to other blocks.

Top module: `pc_sequencer`

## Requirements
- R1: After synchronous reset, `pc` is 0 and `halted` is 0.
- R2: An executed opcode that is neither a push (0x60..0x7F) nor a jump (0x56, 0x57) advances `pc` by 1 and reports `pop_cnt` 0. This includes the marker byte 0x5B.
- R3: An executed push opcode 0x60..0x7F carries n = opcode − 0x5F immediate bytes. It advances `pc` by 1 + n, so the step ranges from 2 for 0x60 to 33 for 0x7F, and it reports `pop_cnt` 0.
- R4: An executed unconditional jump (0x56) reports `pop_cnt` 1. When its destination is valid, `pc` takes the destination value.
- R5: An executed conditional jump (0x57) reports `pop_cnt` 2. When the condition value is nonzero and the destination is valid, `pc` takes the destination value.
- R6: A conditional jump whose condition value is zero advances `pc` by 1. It raises no fault whatever the destination and marker lookup say.
- R7: A destination is valid only when all of its bits above the PC width are zero and `dest_marked` is 1. A taken jump to an invalid destination asserts `fault` in that cycle and leaves `pc` unchanged.
- R8: After a fault, `halted` stays 1 until reset. While halted, executed instructions leave `pc` unchanged, `pop_cnt` stays 0 and `fault` stays 0.
- R9: While `step` is 0, `pc` holds and `pop_cnt` and `fault` are 0.
- R10: `probe_addr` always equals the low PC-width bits of `stk_dest`, and `next_pc` equals the value `pc` holds after the next clock edge.
- R11: PC arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | The instruction at `pc` executes this cycle |
| opcode | input | 8 | Opcode byte at `pc` |
| stk_dest | input | VAL_W | Top of stack, the jump destination |
| stk_cond | input | VAL_W | Second stack entry, the conditional-jump condition |
| dest_marked | input | 1 | Lookup answer: byte at `probe_addr` is a valid jump marker |
| pc | output | PC_W | Current program counter |
| next_pc | output | PC_W | Program counter after the coming edge |
| probe_addr | output | PC_W | Address presented to the marker lookup |
| pop_cnt | output | 2 | Stack entries consumed by this instruction |
| fault | output | 1 | Taken jump to an invalid destination, this cycle |
| halted | output | 1 | Sticky halt after a fault |

## Verification
The assertions check the cycle-local rules on every cycle. These are: the PC advance for plain and push opcodes, the pop counts of both jumps, the PC freezing on fault and while halted, the halt flag never clearing by itself, and the silence of idle cycles. The bench is needed for everything that depends on the values involved. That covers the taken and not-taken outcomes of the conditional jump against a marker map, destinations with bits above the PC width, wrap-around at the top of the address space, and recovery through reset after a halt.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam logic [7:0] OP_JMP     = 8'h56;
    localparam logic [7:0] OP_JMPC    = 8'h57;
    localparam logic [2:0] PUSH_TOP3  = 3'b011;   // 0x60..0x7F

    typedef enum logic [1:0] {
        K_SINGLE,
        K_PUSH,
        K_JMP,
        K_JMPC
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [5:0] imm_len;   // immediate bytes following the opcode
    } op_info_t;

    typedef struct packed {
        logic       taken;     // control transfer requested
        logic       bad;       // requested transfer has an invalid target
        logic [1:0] pops;
    } jump_res_t;

    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        r.kind    = K_SINGLE;
        r.imm_len = '0;
        if (op[7:5] == PUSH_TOP3) begin
            r.kind    = K_PUSH;
            r.imm_len = {1'b0, op[4:0]} + 6'd1;
        end else if (op == OP_JMP) begin
            r.kind = K_JMP;
        end else if (op == OP_JMPC) begin
            r.kind = K_JMPC;
        end
        return r;
    endfunction

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);
    always_comb info = classify(opcode);
endmodule

// File: rtl/pcseq_jump_check.sv
module pcseq_jump_check
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int VAL_W = 32
) (
    input  op_kind_e          kind,
    input  logic [VAL_W-1:0]  dest,
    input  logic [VAL_W-1:0]  cond,
    input  logic              marked,
    output logic [PC_W-1:0]   probe,
    output jump_res_t         res
);
    logic out_of_range;

    generate
        if (VAL_W > PC_W) begin : g_wide
            assign out_of_range = |dest[VAL_W-1:PC_W];
            assign probe        = dest[PC_W-1:0];
        end else begin : g_narrow
            assign out_of_range = 1'b0;
            assign probe        = PC_W'(dest);
        end
    endgenerate

    always_comb begin
        res = '0;
        unique case (kind)
            K_JMP: begin
                res.pops  = 2'd1;
                res.taken = 1'b1;
            end
            K_JMPC: begin
                res.pops  = 2'd2;
                res.taken = |cond;
            end
            default: ;
        endcase
        res.bad = res.taken && (out_of_range || !marked);
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int VAL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [7:0]        opcode,
    input  logic [VAL_W-1:0]  stk_dest,
    input  logic [VAL_W-1:0]  stk_cond,
    input  logic              dest_marked,
    output logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   next_pc,
    output logic [PC_W-1:0]   probe_addr,
    output logic [1:0]        pop_cnt,
    output logic              fault,
    output logic              halted
);
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    op_info_t        info;
    jump_res_t       jres;
    logic [PC_W-1:0] pc_q;
    logic            halt_q;
    logic            live;
    logic [PC_W-1:0] seq_pc;

    pcseq_decode u_dec (
        .opcode (opcode),
        .info   (info)
    );

    pcseq_jump_check #(.PC_W(PC_W), .VAL_W(VAL_W)) u_jchk (
        .kind   (info.kind),
        .dest   (stk_dest),
        .cond   (stk_cond),
        .marked (dest_marked),
        .probe  (probe_addr),
        .res    (jres)
    );

    assign live   = step && !halt_q;
    assign seq_pc = pc_q + PC_ONE + PC_W'(info.imm_len);

    always_comb begin
        next_pc = pc_q;
        fault   = 1'b0;
        pop_cnt = 2'd0;
        if (live) begin
            pop_cnt = jres.pops;
            if (jres.bad)        fault   = 1'b1;
            else if (jres.taken) next_pc = probe_addr;
            else                 next_pc = seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            halt_q <= 1'b0;
        end else begin
            pc_q <= next_pc;
            if (fault) halt_q <= 1'b1;
        end
    end

    assign pc     = pc_q;
    assign halted = halt_q;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            step,
    input logic [7:0]      opcode,
    input logic [PC_W-1:0] pc,
    input logic [1:0]      pop_cnt,
    input logic            fault,
    input logic            halted
);
    logic exec, is_push, is_jmp, is_jmpc;
    assign exec    = step && !halted;
    assign is_push = opcode >= 8'h60 && opcode <= 8'h7F;
    assign is_jmp  = opcode == 8'h56;
    assign is_jmpc = opcode == 8'h57;

    // R2: one-byte advance for ordinary opcodes
    p_single_adv_r2: assert property (@(posedge clk) disable iff (rst)
        (exec && !is_push && !is_jmp && !is_jmpc)
        |=> (pc == $past(pc) + PC_W'(1)));

    // R3: push skips its immediates
    p_push_adv_r3: assert property (@(posedge clk) disable iff (rst)
        (exec && is_push)
        |=> (pc == $past(pc) + PC_W'($past(opcode[4:0])) + PC_W'(2)));

    p_push_pop_r3: assert property (@(posedge clk) disable iff (rst)
        (exec && is_push) |-> (pop_cnt == 2'd0));

    p_jmp_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (exec && is_jmp) |-> (pop_cnt == 2'd1));

    p_jmpc_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (exec && is_jmpc) |-> (pop_cnt == 2'd2));

    // R7: fault only on jumps, and the PC freezes
    p_fault_jump_only_r7: assert property (@(posedge clk) disable iff (rst)
        fault |-> (is_jmp || is_jmpc));

    p_fault_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        fault |=> (halted && $stable(pc)));

    // R8: halt is sticky and silent
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc)));

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!fault && pop_cnt == 2'd0));

    // R9: idle cycles
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !step |-> (!fault && pop_cnt == 2'd0));
endmodule

bind pc_sequencer pcseq_checker #(.PC_W(PC_W)) u_pcseq_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .opcode  (opcode),
    .pc      (pc),
    .pop_cnt (pop_cnt),
    .fault   (fault),
    .halted  (halted)
);

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;
    localparam int PC_W  = 16;
    localparam int VAL_W = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             step;
    logic [7:0]       opcode;
    logic [VAL_W-1:0] stk_dest, stk_cond;
    logic             dest_marked;
    logic [PC_W-1:0]  pc, next_pc, probe_addr;
    logic [1:0]       pop_cnt;
    logic             fault, halted;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    logic [PC_W-1:0] m_pc;
    logic            m_halt;

    always #5 clk = ~clk;

    pc_sequencer #(.PC_W(PC_W), .VAL_W(VAL_W)) dut_i (
        .clk(clk), .rst(rst), .step(step), .opcode(opcode),
        .stk_dest(stk_dest), .stk_cond(stk_cond), .dest_marked(dest_marked),
        .pc(pc), .next_pc(next_pc), .probe_addr(probe_addr),
        .pop_cnt(pop_cnt), .fault(fault), .halted(halted)
    );

    // Marker map used by the bench: addresses congruent to 2 mod 5
    function automatic logic mark_at(input logic [PC_W-1:0] a);
        return (a % 5) == 2;
    endfunction

    always_comb dest_marked = mark_at(probe_addr);

    function automatic logic dest_ok(input logic [VAL_W-1:0] d);
        return (d >> PC_W) == 0 && mark_at(d[PC_W-1:0]);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        m_pc = '0; m_halt = 1'b0;
        #1;
        chk("R1 pc", 64'(pc), 64'(0));
        chk("R1 halted", 64'(halted), 64'(0));
    endtask

    task automatic do_step(input logic s, input logic [7:0] op,
                           input logic [VAL_W-1:0] d, input logic [VAL_W-1:0] c,
                           input string req);
        logic [PC_W-1:0] e_next;
        logic [1:0]      e_pop;
        logic            e_fault;
        logic            taken;
        @(negedge clk);
        step = s; opcode = op; stk_dest = d; stk_cond = c;
        #1;
        e_next = m_pc; e_pop = 0; e_fault = 0;
        if (s && !m_halt) begin
            if (op >= 8'h60 && op <= 8'h7F) begin
                e_next = m_pc + PC_W'(int'(op) - 8'h5F + 1);
            end else if (op == 8'h56 || op == 8'h57) begin
                e_pop = (op == 8'h56) ? 2'd1 : 2'd2;
                taken = (op == 8'h56) || (c != 0);
                if (!taken)          e_next = m_pc + PC_W'(1);
                else if (dest_ok(d)) e_next = d[PC_W-1:0];
                else                 e_fault = 1'b1;
            end else begin
                e_next = m_pc + PC_W'(1);
            end
        end
        chk({req, " pop_cnt"}, 64'(pop_cnt), 64'(e_pop));
        chk({req, " fault"}, 64'(fault), 64'(e_fault));
        chk({req, " next_pc R10"}, 64'(next_pc), 64'(e_next));
        chk("R10 probe_addr", 64'(probe_addr), 64'(d[PC_W-1:0]));
        @(posedge clk); #1;
        m_pc = e_next;
        if (e_fault) m_halt = 1'b1;
        chk({req, " pc"}, 64'(pc), 64'(m_pc));
        chk({req, " halted"}, 64'(halted), 64'(m_halt));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        rst = 1'b1; step = 0; opcode = 0; stk_dest = 0; stk_cond = 0;
        do_reset();

        // R3: worked offsets (push1 at 0 -> 2, push2 at 7 -> 10)
        do_step(1, 8'h60, 0, 0, "R3 push1");
        do_step(1, 8'h60, 0, 0, "R3 push1");
        do_step(1, 8'h01, 0, 0, "R2 plain");
        do_step(1, 8'h20, 0, 0, "R2 plain");
        do_step(1, 8'h5B, 0, 0, "R2 marker byte");
        do_step(1, 8'h61, 0, 0, "R3 push2");
        chk("R3 push2 lands at 10", 64'(pc), 64'(10));
        // R9: idle
        do_step(0, 8'h56, 32'd3, 0, "R9 idle");
        // R4: valid jump
        do_step(1, 8'h56, 32'd12, 0, "R4 jump");
        // R6: zero condition with unmarked target
        do_step(1, 8'h57, 32'd4, 0, "R6 jumpi not taken");
        // R5: taken conditional
        do_step(1, 8'h57, 32'd37, 32'h8000_0000, "R5 jumpi taken");
        // R11: wrap at top of address space via push32
        do_step(1, 8'h56, 32'hFFF7, 0, "R4 jump high");
        do_step(1, 8'h7F, 0, 0, "R11 push32 wrap");
        chk("R11 wrapped pc", 64'(pc), 64'(24));
        // R7: destination above PC width with marked low bits
        do_step(1, 8'h56, 32'h0001_0002, 0, "R7 out of range");
        // R8: halted ignores instructions
        do_step(1, 8'h60, 0, 0, "R8 halted push");
        do_step(1, 8'h56, 32'd2, 0, "R8 halted jump");
        do_reset();
        // R7: unmarked target via conditional
        do_step(1, 8'h57, 32'd3, 32'd1, "R7 unmarked");
        do_step(1, 8'h01, 0, 0, "R8 halted plain");
        do_reset();

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            int unsigned sel;
            logic [7:0]       op;
            logic [VAL_W-1:0] d, c;
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1:    op = 8'($urandom_range(8'h60, 8'h7F));
                2, 3:    op = 8'h56;
                4, 5:    op = 8'h57;
                6:       op = 8'h5B;
                default: op = 8'($urandom_range(0, 255));
            endcase
            if ($urandom_range(0, 9) == 0) d = $urandom();
            else begin
                d = 32'($urandom_range(0, 400));
                if ($urandom_range(0, 3) != 0) d = d - (d % 5) + 2;
            end
            c = ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom();
            do_step($urandom_range(0, 7) != 0, op, d, c, "R2-mix random");
            if (m_halt && $urandom_range(0, 2) == 0) do_reset();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule